// File: doc/BRIEF.md
# Page-Bounded Stream Prefetcher

This block sits beside a first-level cache and watches the demand read requests that the cache makes. Each request arrives as a physical line address, which is a byte address with its low six bits dropped. The block looks for runs of neighbouring lines inside one 4 KiB page, in either the upward or the downward direction. When a run is confirmed, it asks for the lines just ahead of the most recent access, up to two lines beyond it.

The block follows up to four such runs at once. Each run is keyed by its page number, and when a new page needs a slot, the run used least recently is replaced. Prefetch requests leave through a valid/ready handshake and wait as long as the consumer needs.

The block never requests a line outside the page of the access that led to the request. A run that reaches the end of a page stops there. Prefetching in the next page starts again only after demand accesses in that page have confirmed a new run.

Top module: `page_stream_prefetcher`

## Requirements
- R1: A line address is split into a page number (all bits above bit 5) and a line offset (bits 5..0), so that each 4 KiB page holds the 64 offsets 0 to 63. Two lines belong to the same stream only when their page numbers are equal.
- R2: A stream is confirmed when a demand access in a page comes straight after an earlier access in the same page whose offset differs by +1 (upward) or -1 (downward). Until a stream is confirmed, no prefetch is issued for that page.
- R3: After each access that confirms or extends a stream at offset o in direction d, the lines o+d and o+2d become due, in that order, with the nearest line first.
- R4: No prefetch names an offset outside 0..63 of the page that triggered it. Upward accesses at offset 63 and downward accesses at offset 0 make nothing due.
- R5: The first access to a page that is not being tracked starts an unconfirmed stream and issues no prefetch. This holds even when the access follows on from a run in the neighbouring page.
- R6: In a confirmed stream, an access whose offset step is not the stream's direction returns the stream to unconfirmed and issues nothing. The access after it can confirm a new stream in either direction.
- R7: At most four pages are tracked at once. A miss takes the lowest-numbered free slot, or else replaces the page used least recently. A replaced page that is accessed again starts unconfirmed.
- R8: A line is issued at most once by a stream. A line that the demand stream has already reached before it could be issued is skipped.
- R9: While pf_valid is high and pf_ready is low, pf_valid stays high and pf_line stays the same in the next cycle. No due line is dropped.
- R10: During reset and right after it, pf_valid is low and no stream is tracked. Demand inputs during reset have no effect.
- R11: A demand access that updates a stream's slot blocks that slot from issuing in the same cycle. Its next line is chosen after the update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dmd_vld | input | 1 | A demand read is present this cycle |
| dmd_line | input | LINE_AW | Physical line address of the demand read |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_ready | input | 1 | The consumer takes the offered request |
| pf_line | output | LINE_AW | Physical line address to prefetch |

## Verification
Two things can happen to the same stream in the same clock cycle: a demand access updates it, and its next due line is moved into the output slot. The bench sets up both orders under a stalled consumer. In one case the third access of a run comes right after the second. In the other case it comes one idle cycle later, after line o+1 has already been placed in the slot. The bench then judges the exact line sequence: back to back must give only the two lines past the third access, and the gapped case must keep the line already in the slot and then add the two lines after it. It also checks that the output slot holds its line unchanged while the consumer stalls.

// File: rtl/pfx_pkg.sv
// Package pfx_pkg
// Shared definitions for the page-bounded stream prefetcher: stream
// direction encoding and a width helper. Assumes nothing else.
package pfx_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } pf_dir_e;

    // Index width for a table of n entries, never less than one bit.
    function automatic int clog2_min1(input int n);
        int w;
        w = 1;
        while ((1 << w) < n) w++;
        return w;
    endfunction

endpackage

// File: rtl/pfx_lookup.sv
// Module pfx_lookup
// Combinational page match over the stream table. Reports which entry holds
// the requested page, and which entry a miss should replace: the lowest free
// entry, or else the one whose age says it was used least recently.
// Assumes the ages of the entries form a permutation of 0..N_STREAMS-1.
module pfx_lookup #(
    parameter int N_STREAMS = 4,
    parameter int PAGE_W    = 20,
    parameter int IDX_W     = 2
) (
    input  logic              ent_vld  [N_STREAMS],
    input  logic [PAGE_W-1:0] ent_tag  [N_STREAMS],
    input  logic [IDX_W-1:0]  ent_age  [N_STREAMS],
    input  logic [PAGE_W-1:0] req_page,
    output logic [N_STREAMS-1:0] hit_vec,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output logic [IDX_W-1:0]  vic_idx
);
    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(N_STREAMS - 1);

    // Tag compare across all entries.
    always_comb begin
        hit_vec = '0;
        hit_idx = '0;
        for (int i = 0; i < N_STREAMS; i++) begin
            if (ent_vld[i] && ent_tag[i] == req_page) begin
                hit_vec[i] = 1'b1;
                hit_idx    = IDX_W'(i);
            end
        end
    end

    assign hit = |hit_vec;

    // Victim choice: the oldest entry, overridden by the lowest free entry.
    always_comb begin
        vic_idx = '0;
        for (int i = N_STREAMS - 1; i >= 0; i--) begin
            if (ent_age[i] == OLDEST) vic_idx = IDX_W'(i);
        end
        for (int i = N_STREAMS - 1; i >= 0; i--) begin
            if (!ent_vld[i]) vic_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/pfx_stream_table.sv
// Module pfx_stream_table
// Holds one tracked stream per entry: page tag, last demand offset,
// confirmation, direction, the next line to issue and the furthest line
// due. Also holds the age used for replacement. One demand update and one
// issue advance may arrive per cycle; they never target the same entry.
// Assumes PF_DIST is smaller than the number of lines in a page.
module pfx_stream_table
    import pfx_pkg::*;
#(
    parameter int N_STREAMS = 4,
    parameter int OFF_W     = 6,
    parameter int PAGE_W    = 20,
    parameter int PF_DIST   = 2,
    parameter int IDX_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dmd_vld,
    input  logic [PAGE_W-1:0] dmd_page,
    input  logic [OFF_W-1:0]  dmd_off,
    input  logic [IDX_W-1:0]  sel_idx,
    input  logic              sel_hit,
    input  logic              take_vld,
    input  logic [IDX_W-1:0]  take_idx,
    output logic              ent_vld     [N_STREAMS],
    output logic [PAGE_W-1:0] ent_tag     [N_STREAMS],
    output logic [IDX_W-1:0]  ent_age     [N_STREAMS],
    output logic [OFF_W-1:0]  ent_nxt_off [N_STREAMS],
    output logic [N_STREAMS-1:0] ent_pend
);
    localparam int SW = OFF_W + 2;
    localparam logic signed [SW-1:0] MAX_OFF = SW'((1 << OFF_W) - 1);
    localparam logic signed [SW-1:0] ONE     = SW'(1);
    localparam logic signed [SW-1:0] REACH   = SW'(PF_DIST);

    logic signed [SW-1:0] dmd_off_s;
    assign dmd_off_s = $signed({2'b00, dmd_off});

    // Furthest due offset for an access at o, clipped to the page.
    function automatic logic signed [SW-1:0] clip_goal(input logic signed [SW-1:0] o,
                                                       input logic down);
        logic signed [SW-1:0] g;
        g = down ? (o - REACH) : (o + REACH);
        if (g < 0)            g = '0;
        else if (g > MAX_OFF) g = MAX_OFF;
        return g;
    endfunction

    for (genvar i = 0; i < N_STREAMS; i++) begin : g_ent
        logic                 vld_q;
        logic [PAGE_W-1:0]    tag_q;
        logic [OFF_W-1:0]     last_q;
        logic                 conf_q;
        pf_dir_e              dir_q;
        logic signed [SW-1:0] nxt_q;
        logic signed [SW-1:0] goal_q;
        logic [IDX_W-1:0]     age_q;

        logic signed [SW-1:0] step_c;
        logic signed [SW-1:0] delta_c;
        logic signed [SW-1:0] lead_c;
        logic                 behind_c;
        logic                 mine_c;
        logic                 took_c;

        // Per-entry decode of the incoming demand against this stream.
        always_comb begin
            step_c   = (dir_q == DIR_DOWN) ? -ONE : ONE;
            delta_c  = dmd_off_s - $signed({2'b00, last_q});
            lead_c   = dmd_off_s + step_c;
            behind_c = (dir_q == DIR_DOWN) ? (nxt_q > lead_c) : (nxt_q < lead_c);
            mine_c   = dmd_vld && (sel_idx == IDX_W'(i));
            took_c   = take_vld && (take_idx == IDX_W'(i));
        end

        // Stream state: allocate, confirm, extend, break, or advance on issue.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q  <= 1'b0;
                tag_q  <= '0;
                last_q <= '0;
                conf_q <= 1'b0;
                dir_q  <= DIR_UP;
                nxt_q  <= '0;
                goal_q <= '0;
            end else if (mine_c && !sel_hit) begin
                vld_q  <= 1'b1;
                tag_q  <= dmd_page;
                last_q <= dmd_off;
                conf_q <= 1'b0;
            end else if (mine_c) begin
                last_q <= dmd_off;
                if (conf_q) begin
                    if (delta_c == step_c) begin
                        goal_q <= clip_goal(dmd_off_s, dir_q == DIR_DOWN);
                        if (behind_c) nxt_q <= lead_c;
                    end else begin
                        conf_q <= 1'b0;
                    end
                end else if (delta_c == ONE || delta_c == -ONE) begin
                    conf_q <= 1'b1;
                    dir_q  <= (delta_c < 0) ? DIR_DOWN : DIR_UP;
                    nxt_q  <= dmd_off_s + delta_c;
                    goal_q <= clip_goal(dmd_off_s, delta_c < 0);
                end
            end else if (took_c) begin
                nxt_q <= nxt_q + step_c;
            end
        end

        // Recency age: the touched entry becomes youngest, younger ones age.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                age_q <= IDX_W'(i);
            end else if (dmd_vld) begin
                if (mine_c)                       age_q <= '0;
                else if (age_q < ent_age[sel_idx]) age_q <= age_q + 1'b1;
            end
        end

        assign ent_vld[i]     = vld_q;
        assign ent_tag[i]     = tag_q;
        assign ent_age[i]     = age_q;
        assign ent_nxt_off[i] = nxt_q[OFF_W-1:0];
        assign ent_pend[i]    = vld_q && conf_q &&
                                ((dir_q == DIR_DOWN) ? (nxt_q >= goal_q) : (nxt_q <= goal_q));

        // R4
        pend_in_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ent_pend[i] |-> (nxt_q >= 0 && nxt_q <= MAX_OFF));

        // R5
        alloc_unconf_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mine_c && !sel_hit) |=> !ent_pend[i]);
    end

endmodule

// File: rtl/pfx_issue.sv
// Module pfx_issue
// Output slot for prefetch requests. When the slot is empty or being taken,
// it loads the next due line of the lowest-numbered pending entry. An entry
// that a demand access touches this cycle is not eligible. Assumes the
// table advances the chosen entry when take_vld is high.
module pfx_issue #(
    parameter int N_STREAMS = 4,
    parameter int OFF_W     = 6,
    parameter int PAGE_W    = 20,
    parameter int IDX_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_STREAMS-1:0] ent_pend,
    input  logic [PAGE_W-1:0] ent_tag     [N_STREAMS],
    input  logic [OFF_W-1:0]  ent_nxt_off [N_STREAMS],
    input  logic              dmd_vld,
    input  logic [IDX_W-1:0]  dmd_idx,
    input  logic              pf_ready,
    output logic              pf_valid,
    output logic [PAGE_W+OFF_W-1:0] pf_line,
    output logic              take_vld,
    output logic [IDX_W-1:0]  take_idx
);
    logic                    slot_vld_q;
    logic [PAGE_W+OFF_W-1:0] slot_line_q;
    logic                    slot_free;

    assign slot_free = !slot_vld_q || pf_ready;

    // Fixed-priority pick of the lowest eligible pending entry.
    always_comb begin
        take_vld = 1'b0;
        take_idx = '0;
        for (int i = N_STREAMS - 1; i >= 0; i--) begin
            if (slot_free && ent_pend[i] && !(dmd_vld && dmd_idx == IDX_W'(i))) begin
                take_vld = 1'b1;
                take_idx = IDX_W'(i);
            end
        end
    end

    // Slot register: load on take, empty on accept with nothing to load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_vld_q  <= 1'b0;
            slot_line_q <= '0;
        end else if (take_vld) begin
            slot_vld_q  <= 1'b1;
            slot_line_q <= {ent_tag[take_idx], ent_nxt_off[take_idx]};
        end else if (pf_ready) begin
            slot_vld_q  <= 1'b0;
        end
    end

    assign pf_valid = slot_vld_q;
    assign pf_line  = slot_line_q;

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_line)));

    // R11
    take_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dmd_vld && take_vld) |-> (take_idx != dmd_idx));

endmodule

// File: rtl/page_stream_prefetcher.sv
// Module page_stream_prefetcher
// Top level: splits the demand line into page and offset, looks the page up
// in the stream table, updates the chosen entry and feeds due lines to the
// handshake output. Assumes one demand access per cycle at most and a
// synchronous active-low reset.
module page_stream_prefetcher #(
    parameter int LINE_AW       = 26,
    parameter int PG_LINES_LOG2 = 6,
    parameter int N_STREAMS     = 4,
    parameter int PF_DIST       = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dmd_vld,
    input  logic [LINE_AW-1:0] dmd_line,
    output logic               pf_valid,
    input  logic               pf_ready,
    output logic [LINE_AW-1:0] pf_line
);
    localparam int OFF_W  = PG_LINES_LOG2;
    localparam int PAGE_W = LINE_AW - OFF_W;
    localparam int IDX_W  = pfx_pkg::clog2_min1(N_STREAMS);

    logic [PAGE_W-1:0]    dmd_page;
    logic [OFF_W-1:0]     dmd_off;
    logic                 ent_vld     [N_STREAMS];
    logic [PAGE_W-1:0]    ent_tag     [N_STREAMS];
    logic [IDX_W-1:0]     ent_age     [N_STREAMS];
    logic [OFF_W-1:0]     ent_nxt_off [N_STREAMS];
    logic [N_STREAMS-1:0] ent_pend;
    logic [N_STREAMS-1:0] hit_vec;
    logic                 hit;
    logic [IDX_W-1:0]     hit_idx;
    logic [IDX_W-1:0]     vic_idx;
    logic [IDX_W-1:0]     sel_idx;
    logic                 take_vld;
    logic [IDX_W-1:0]     take_idx;

    assign dmd_page = dmd_line[LINE_AW-1:OFF_W];
    assign dmd_off  = dmd_line[OFF_W-1:0];
    assign sel_idx  = hit ? hit_idx : vic_idx;

    pfx_lookup #(
        .N_STREAMS (N_STREAMS),
        .PAGE_W    (PAGE_W),
        .IDX_W     (IDX_W)
    ) u_lookup (
        .ent_vld  (ent_vld),
        .ent_tag  (ent_tag),
        .ent_age  (ent_age),
        .req_page (dmd_page),
        .hit_vec  (hit_vec),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .vic_idx  (vic_idx)
    );

    pfx_stream_table #(
        .N_STREAMS (N_STREAMS),
        .OFF_W     (OFF_W),
        .PAGE_W    (PAGE_W),
        .PF_DIST   (PF_DIST),
        .IDX_W     (IDX_W)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .dmd_vld     (dmd_vld),
        .dmd_page    (dmd_page),
        .dmd_off     (dmd_off),
        .sel_idx     (sel_idx),
        .sel_hit     (hit),
        .take_vld    (take_vld),
        .take_idx    (take_idx),
        .ent_vld     (ent_vld),
        .ent_tag     (ent_tag),
        .ent_age     (ent_age),
        .ent_nxt_off (ent_nxt_off),
        .ent_pend    (ent_pend)
    );

    pfx_issue #(
        .N_STREAMS (N_STREAMS),
        .OFF_W     (OFF_W),
        .PAGE_W    (PAGE_W),
        .IDX_W     (IDX_W)
    ) u_issue (
        .clk         (clk),
        .rst_n       (rst_n),
        .ent_pend    (ent_pend),
        .ent_tag     (ent_tag),
        .ent_nxt_off (ent_nxt_off),
        .dmd_vld     (dmd_vld),
        .dmd_idx     (sel_idx),
        .pf_ready    (pf_ready),
        .pf_valid    (pf_valid),
        .pf_line     (pf_line),
        .take_vld    (take_vld),
        .take_idx    (take_idx)
    );

    // R7
    hit_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmd_vld |-> $onehot0(hit_vec));

endmodule

// File: tb/page_stream_prefetcher_test.sv
// Bench for page_stream_prefetcher: directed corner cases with hand-computed
// line lists, then a seeded random mix of pages checked against a
// transaction-level model of the stream rules.
module page_stream_prefetcher_test;
    localparam int LAW = 26;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           dmd_vld = 1'b0;
    logic [LAW-1:0] dmd_line = '0;
    logic           pf_ready = 1'b0;
    logic           pf_valid;
    logic [LAW-1:0] pf_line;

    always #10 clk = ~clk;

    page_stream_prefetcher uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .dmd_vld  (dmd_vld),
        .dmd_line (dmd_line),
        .pf_valid (pf_valid),
        .pf_ready (pf_ready),
        .pf_line  (pf_line)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int got_q[$];
    int exp_q[$];

    // Reference model state (one row per tracked page).
    bit          m_v    [4];
    int          m_tag  [4];
    int          m_last [4];
    bit          m_conf [4];
    int          m_dir  [4];
    int          m_nxt  [4];
    int          m_goal [4];
    int unsigned m_ts   [4];
    int unsigned m_now;

    function automatic int L(input int pg, input int off);
        return pg * 64 + off;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, record a handshake the next rise takes.
    task automatic step(input bit v, input int line, input bit rdy);
        @(negedge clk);
        dmd_vld  = v;
        dmd_line = LAW'(line);
        pf_ready = rdy;
        #1;
        if (rst_n && pf_valid && pf_ready) got_q.push_back(int'(pf_line));
    endtask

    task automatic drain(input bit rnd);
        for (int k = 0; k < 30; k++) step(1'b0, 0, rnd ? ($urandom_range(0, 3) != 0) : 1'b1);
        for (int k = 0; k < 6; k++) step(1'b0, 0, 1'b1);
    endtask

    task automatic acc(input int pg, input int off);
        step(1'b1, L(pg, off), 1'b1);
        drain(1'b0);
    endtask

    task automatic expect_lines(input string req, input string what, input int n,
                                input int e0 = 0, input int e1 = 0, input int e2 = 0);
        int  e[3];
        bit  ok;
        int  act;
        int  ex;
        e   = '{e0, e1, e2};
        ok  = (got_q.size() == n);
        act = got_q.size();
        ex  = n;
        for (int k = 0; k < n; k++) begin
            if (ok && got_q[k] != e[k]) begin
                ok  = 1'b0;
                act = got_q[k];
                ex  = e[k];
            end
        end
        chk(ok, req, what, act, ex);
        got_q.delete();
    endtask

    task automatic model_clear();
        for (int i = 0; i < 4; i++) begin
            m_v[i]  = 1'b0;
            m_ts[i] = 0;
        end
        m_now = 0;
        exp_q.delete();
    endtask

    function automatic int model_goal(input int off, input int dir);
        int g;
        g = off + 2 * dir;
        if (g < 0)  g = 0;
        if (g > 63) g = 63;
        return g;
    endfunction

    // Applies one access to the model and appends the lines it makes due.
    task automatic model_access(input int pg, input int off);
        int e;
        int d;
        e = -1;
        for (int i = 0; i < 4; i++) if (m_v[i] && m_tag[i] == pg) e = i;
        m_now++;
        if (e < 0) begin
            for (int i = 3; i >= 0; i--) if (!m_v[i]) e = i;
            if (e < 0) begin
                e = 0;
                for (int i = 1; i < 4; i++) if (m_ts[i] < m_ts[e]) e = i;
            end
            m_v[e] = 1'b1; m_tag[e] = pg; m_last[e] = off; m_conf[e] = 1'b0; m_ts[e] = m_now;
            return;
        end
        m_ts[e] = m_now;
        d = off - m_last[e];
        if (m_conf[e]) begin
            if (d == m_dir[e]) begin
                m_goal[e] = model_goal(off, m_dir[e]);
                if ((m_dir[e] > 0 && m_nxt[e] < off + 1) || (m_dir[e] < 0 && m_nxt[e] > off - 1))
                    m_nxt[e] = off + m_dir[e];
            end else begin
                m_conf[e] = 1'b0;
            end
        end else if (d == 1 || d == -1) begin
            m_conf[e] = 1'b1; m_dir[e] = d; m_nxt[e] = off + d; m_goal[e] = model_goal(off, d);
        end
        m_last[e] = off;
        if (m_conf[e]) begin
            while ((m_dir[e] > 0 && m_nxt[e] <= m_goal[e]) || (m_dir[e] < 0 && m_nxt[e] >= m_goal[e])) begin
                exp_q.push_back(L(pg, m_nxt[e]));
                m_nxt[e] += m_dir[e];
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        step(1'b1, L(5, 5), 1'b1);
        step(1'b1, L(5, 6), 1'b1);
        step(1'b0, 0, 1'b1);
        chk(pf_valid == 1'b0, "R10", "pf_valid during reset", int'(pf_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(pf_valid == 1'b0, "R10", "pf_valid after reset", int'(pf_valid), 0);
        got_q.delete();
        model_clear();
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int          pg [6];
        int          cur[6];
        int          cdr[6];
        int          s;
        int          r;
        int          first;
        bit          ok;
        void'($urandom(32'h5eed_1234));

        do_reset();
        // R2: single access, then an upward pair, then R8 extension
        acc(100, 10);
        expect_lines("R2", "lone access", 0);
        acc(100, 11);
        expect_lines("R2", "upward pair", 2, L(100, 12), L(100, 13));
        acc(100, 12);
        expect_lines("R8", "extend without re-issue", 1, L(100, 14));
        // R3: downward pair
        acc(200, 40);
        acc(200, 39);
        expect_lines("R3", "downward pair", 2, L(200, 38), L(200, 37));
        // R4: upper page edge, then R5/R1 next page
        do_reset();
        acc(300, 61);
        acc(300, 62);
        expect_lines("R4", "top edge clip", 1, L(300, 63));
        acc(300, 63);
        expect_lines("R4", "at offset 63", 0);
        acc(301, 0);
        expect_lines("R5", "new page entry", 0);
        acc(301, 1);
        expect_lines("R1", "next page confirm", 2, L(301, 2), L(301, 3));
        // R4: lower page edge
        acc(400, 2);
        acc(400, 1);
        expect_lines("R4", "bottom edge clip", 1, L(400, 0));
        acc(400, 0);
        expect_lines("R4", "at offset 0", 0);
        // R6: break and reconfirm, also in the other direction
        do_reset();
        acc(500, 20);
        acc(500, 21);
        expect_lines("R6", "before break", 2, L(500, 22), L(500, 23));
        acc(500, 30);
        expect_lines("R6", "break", 0);
        acc(500, 31);
        expect_lines("R6", "reconfirm up", 2, L(500, 32), L(500, 33));
        acc(500, 30);
        expect_lines("R6", "reverse step breaks", 0);
        acc(500, 29);
        expect_lines("R6", "reconfirm down", 2, L(500, 28), L(500, 27));
        // R7: replacement of the least recently used page
        do_reset();
        acc(600, 5);
        acc(600, 6);
        expect_lines("R7", "stream A", 2, L(600, 7), L(600, 8));
        acc(601, 0);
        acc(602, 0);
        acc(603, 0);
        acc(604, 0);
        acc(600, 7);
        expect_lines("R7", "evicted page restarts", 0);
        do_reset();
        acc(600, 5);
        acc(600, 6);
        acc(601, 0);
        acc(602, 0);
        acc(603, 0);
        acc(600, 7);
        expect_lines("R7", "kept page continues", 3, L(600, 7), L(600, 8), L(600, 9));
        acc(604, 0);
        acc(601, 1);
        expect_lines("R7", "oldest page replaced", 0);
        acc(600, 8);
        expect_lines("R7", "recent page survives", 1, L(600, 10));
        // R9: stalled consumer keeps the offered line
        do_reset();
        step(1'b1, L(700, 10), 1'b0);
        step(1'b1, L(700, 11), 1'b0);
        step(1'b0, 0, 1'b0);
        step(1'b0, 0, 1'b0);
        first = int'(pf_line);
        ok    = pf_valid;
        for (int k = 0; k < 8; k++) begin
            step(1'b0, 0, 1'b0);
            if (!pf_valid || int'(pf_line) != first) ok = 1'b0;
        end
        chk(ok, "R9", "held under stall", first, L(700, 12));
        chk(first == L(700, 12), "R9", "offered line", first, L(700, 12));
        drain(1'b0);
        expect_lines("R9", "nothing dropped", 2, L(700, 12), L(700, 13));
        // R11: back-to-back third access blocks issue of the same stream
        do_reset();
        step(1'b1, L(800, 10), 1'b0);
        step(1'b1, L(800, 11), 1'b0);
        step(1'b1, L(800, 12), 1'b0);
        drain(1'b0);
        expect_lines("R11", "back-to-back under stall", 2, L(800, 13), L(800, 14));
        // R11: one idle cycle lets line 12 reach the slot first
        do_reset();
        step(1'b1, L(810, 10), 1'b0);
        step(1'b1, L(810, 11), 1'b0);
        step(1'b0, 0, 1'b0);
        step(1'b1, L(810, 12), 1'b0);
        drain(1'b0);
        expect_lines("R11", "gapped under stall", 3, L(810, 12), L(810, 13), L(810, 14));
        // R8: demand outruns issue every cycle; passed lines are skipped
        do_reset();
        step(1'b1, L(820, 10), 1'b1);
        step(1'b1, L(820, 11), 1'b1);
        step(1'b1, L(820, 12), 1'b1);
        step(1'b1, L(820, 13), 1'b1);
        drain(1'b0);
        expect_lines("R8", "streaming every cycle", 2, L(820, 14), L(820, 15));

        // Random mix over six pages (forces replacement): R2 R3 R6 R7
        do_reset();
        for (int i = 0; i < 6; i++) begin
            pg[i]  = 1000 + i * 37 + $urandom_range(0, 30);
            cur[i] = $urandom_range(0, 63);
            cdr[i] = ($urandom_range(0, 1) != 0) ? 1 : -1;
        end
        for (int k = 0; k < 300; k++) begin
            s = $urandom_range(0, 5);
            r = $urandom_range(0, 99);
            if (r < 70) cur[s] += cdr[s];
            else if (r < 82) begin
                cdr[s] = -cdr[s];
                cur[s] += cdr[s];
            end else cur[s] = $urandom_range(0, 63);
            if (cur[s] < 0 || cur[s] > 63) cur[s] = $urandom_range(0, 63);
            model_access(pg[s], cur[s]);
            step(1'b1, L(pg[s], cur[s]), $urandom_range(0, 1) != 0);
            drain(1'b1);
            ok = (got_q.size() == exp_q.size());
            for (int j = 0; j < exp_q.size(); j++) if (ok && got_q[j] != exp_q[j]) ok = 1'b0;
            chk(ok, "R3", "random mix lines",
                got_q.size() > 0 ? got_q[0] : -1, exp_q.size() > 0 ? exp_q[0] : -1);
            got_q.delete();
            exp_q.delete();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule